// File: doc/BRIEF.md
# Threshold-Gated Interrupt Claim Arbiter

This block sits between a set of level-sensitive interrupt sources and several interrupt targets, called contexts. It keeps one pending bit and one in-service bit per source. Each context has its own enable mask and its own priority threshold. For every context it looks for sources that are pending, enabled for that context, not already in service and above the context's threshold. If it finds one, it raises that context's request line.

A context takes an interrupt by pulsing a claim strobe. In the same cycle the block returns the best source number on `claim_id`. On the next clock edge that source moves from pending to in service. When the handler finishes, it pulses a completion strobe with the source number, and the in-service bit is cleared. Source number 0 does not exist and stands for "nothing to take".

Each context is built as either a machine-level or a supervisor-level target, chosen by the `CTX_SUP` parameter. That choice decides which of the two request outputs the context drives.

Top module: `irq_claim_arb`

## Requirements
- R1: A source counts for a context only if its pending bit is set, its in-service bit is clear and that context's enable bit for it is set.
- R2: A counted source qualifies only if its priority is strictly greater than the context's threshold. Priority 0 never qualifies, and a priority equal to the threshold is masked.
- R3: `claim_id` is the qualifying source with the largest priority. Among sources with equal priority, the smallest source number wins.
- R4: A claim with no qualifying source returns 0 and leaves pending and in-service state unchanged.
- R5: A claim returning source n clears pending bit n and sets in-service bit n, both at the next clock edge.
- R6: A completion with ID n clears in-service bit n when n < NSRC. Any larger ID has no effect.
- R7: Each context drives only one output: `s_irq[c]` when bit c of `CTX_SUP` is 1, and `m_irq[c]` otherwise. The output it drives is high exactly when at least one source qualifies for that context. The other output stays 0.
- R8: The pending bit of source s takes the value of `src_level[s]` at each clock edge, except in a cycle where s wins a claim.
- R9: The request line of a context falls in the cycle after the claim that removes its last qualifying source.
- R10: After reset all state is 0: no request line is high and a claim returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | NSRC | Interrupt level of each source (bit 0 unused) |
| prio_we | input | 1 | Write strobe for a source priority |
| prio_idx | input | IDW | Source whose priority is written (index 0 ignored) |
| prio_val | input | PW | New priority |
| en_we | input | 1 | Write strobe for a context enable mask |
| en_ctx | input | CW | Context whose enable mask is written |
| en_mask | input | NSRC | New enable mask |
| thr_we | input | 1 | Write strobe for a context threshold |
| thr_ctx | input | CW | Context whose threshold is written |
| thr_val | input | PW | New threshold |
| claim_req | input | 1 | Claim strobe |
| claim_ctx | input | CW | Context making the claim |
| claim_id | output | IDW | Winning source for the claim, 0 if none |
| cmpl_req | input | 1 | Completion strobe |
| cmpl_id | input | IDW+1 | Source being completed |
| m_irq | output | NCTX | Machine-level request per context |
| s_irq | output | NCTX | Supervisor-level request per context |

## Verification
The assertions check on every cycle:
- every nonzero claim result is a source that is pending, not in service, enabled for the claiming context and above its threshold;
- a win moves the source from pending to in service on the next edge;
- an out-of-range completion leaves the in-service bits unchanged;
- each context drives only the output its mode selects.

Some behaviour can only be shown by the bench's scenarios against its reference model. This covers which source wins among several candidates, including the lowest-number rule on ties. It also covers the one-cycle delay from a level change to the request line, the drop of the line after the last claim, and the masking at a priority equal to the threshold.

// File: rtl/irq_claim_arb.sv
module irq_claim_arb #(
  parameter int NSRC = 16,
  parameter int NCTX = 2,
  parameter int PW   = 3,
  parameter logic [NCTX-1:0] CTX_SUP = 2'b10,
  localparam int IDW = $clog2(NSRC),
  localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_level,
  input  logic            prio_we,
  input  logic [IDW-1:0]  prio_idx,
  input  logic [PW-1:0]   prio_val,
  input  logic            en_we,
  input  logic [CW-1:0]   en_ctx,
  input  logic [NSRC-1:0] en_mask,
  input  logic            thr_we,
  input  logic [CW-1:0]   thr_ctx,
  input  logic [PW-1:0]   thr_val,
  input  logic            claim_req,
  input  logic [CW-1:0]   claim_ctx,
  output logic [IDW-1:0]  claim_id,
  input  logic            cmpl_req,
  input  logic [IDW:0]    cmpl_id,
  output logic [NCTX-1:0] m_irq,
  output logic [NCTX-1:0] s_irq
);

  localparam logic [IDW:0]    LIMIT = (IDW+1)'(NSRC);
  localparam logic [NSRC-1:0] NO_ZERO = ~(NSRC'(1));

  logic [NSRC-1:0] pend, clm;
  logic [NSRC-1:0] en [NCTX];
  logic [PW-1:0]   prio [NSRC];
  logic [PW-1:0]   thr [NCTX];
  logic [NCTX*IDW-1:0] bid_flat;
  logic [NCTX-1:0] hit;
  logic            cmpl_ok;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [NSRC-1:0] elig;
    logic [PW-1:0]   bp;
    logic [IDW-1:0]  bid;

    assign elig = pend & ~clm & en[c];

    always_comb begin
      bp  = thr[c];
      bid = '0;
      for (int s = 1; s < NSRC; s++) begin
        if (elig[s] && prio[s] > bp) begin
          bp  = prio[s];
          bid = IDW'(s);
        end
      end
    end

    assign bid_flat[c*IDW +: IDW] = bid;
    assign hit[c]   = (bid != '0);
    assign m_irq[c] = hit[c] & ~CTX_SUP[c];
    assign s_irq[c] = hit[c] &  CTX_SUP[c];

    assert_mode_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (CTX_SUP[c] ? !m_irq[c] : !s_irq[c]) && ($countones({m_irq[c], s_irq[c]}) <= 1));
  end

  assign claim_id = claim_req ? bid_flat[claim_ctx*IDW +: IDW] : '0;
  assign cmpl_ok  = cmpl_req && (cmpl_id < LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      clm  <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
      for (int s = 0; s < NSRC; s++) prio[s] <= '0;
    end else begin
      pend <= src_level & NO_ZERO;
      if (claim_id != '0) pend[claim_id] <= 1'b0;
      if (cmpl_ok) clm[cmpl_id[IDW-1:0]] <= 1'b0;
      if (claim_id != '0) clm[claim_id] <= 1'b1;
      if (prio_we && prio_idx != '0) prio[prio_idx] <= prio_val;
      if (en_we) en[en_ctx] <= en_mask & NO_ZERO;
      if (thr_we) thr[thr_ctx] <= thr_val;
    end
  end

  assert_claim_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_id != '0) |-> (pend[claim_id] && !clm[claim_id] && en[claim_ctx][claim_id]));

  assert_claim_above_thr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_id != '0) |-> (prio[claim_id] > thr[claim_ctx]));

  assert_claim_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_id != '0) |=> (clm[$past(claim_id)] && !pend[$past(claim_id)]));

  assert_cmpl_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_req && !cmpl_ok && claim_id == '0) |=> $stable(clm));

endmodule

// File: tb/sim_irq_claim_arb.sv
`timescale 1ns/1ps
module sim_irq_claim_arb;
  localparam int NSRC = 16, NCTX = 2, PW = 3;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_level = '0, en_mask = '0;
  logic prio_we = 0, en_we = 0, thr_we = 0, claim_req = 0, cmpl_req = 0;
  logic [3:0] prio_idx = '0, claim_id;
  logic [PW-1:0] prio_val = '0, thr_val = '0;
  logic en_ctx = 0, thr_ctx = 0, claim_ctx = 0;
  logic [4:0] cmpl_id = '0;
  logic [NCTX-1:0] m_irq, s_irq;

  int compared = 0, mismatched = 0;
  bit done = 0;

  int  mprio [NSRC];
  bit  mpend [NSRC], mclm [NSRC];
  bit  men [NCTX][NSRC];
  int  mthr [NCTX];
  bit  msup [NCTX] = '{0, 1};

  always #10 clk = ~clk;

  irq_claim_arb u0 (.clk(clk), .rst_n(rst_n), .src_level(src_level),
    .prio_we(prio_we), .prio_idx(prio_idx), .prio_val(prio_val),
    .en_we(en_we), .en_ctx(en_ctx), .en_mask(en_mask),
    .thr_we(thr_we), .thr_ctx(thr_ctx), .thr_val(thr_val),
    .claim_req(claim_req), .claim_ctx(claim_ctx), .claim_id(claim_id),
    .cmpl_req(cmpl_req), .cmpl_id(cmpl_id), .m_irq(m_irq), .s_irq(s_irq));

  function automatic int best(int c);
    int b = mthr[c], id = 0;
    for (int s = 1; s < NSRC; s++)
      if (mpend[s] && !mclm[s] && men[c][s] && mprio[s] > b) begin b = mprio[s]; id = s; end
    return id;
  endfunction

  task automatic chk(int act, int exp, string tag);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    int w;
    #1;
    for (int c = 0; c < NCTX; c++) begin
      chk(int'(m_irq[c]), (!msup[c] && best(c) != 0) ? 1 : 0, {tag, " m_irq"});
      chk(int'(s_irq[c]), ( msup[c] && best(c) != 0) ? 1 : 0, {tag, " s_irq"});
    end
    w = claim_req ? best(int'(claim_ctx)) : 0;
    chk(int'(claim_id), w, {tag, " claim_id"});
    @(posedge clk);
    for (int s = 1; s < NSRC; s++) mpend[s] = src_level[s];
    if (cmpl_req && cmpl_id < NSRC) mclm[cmpl_id] = 0;
    if (w != 0) begin mpend[w] = 0; mclm[w] = 1; end
    if (prio_we && prio_idx != 0) mprio[prio_idx] = int'(prio_val);
    if (en_we) for (int s = 1; s < NSRC; s++) men[en_ctx][s] = en_mask[s];
    if (thr_we) mthr[thr_ctx] = int'(thr_val);
    @(negedge clk);
    prio_we = 0; en_we = 0; thr_we = 0; claim_req = 0; cmpl_req = 0;
  endtask

  task automatic set_prio(int s, int p);
    prio_we = 1; prio_idx = 4'(s); prio_val = PW'(p); step("R3 cfg");
  endtask

  task automatic claim(int c, int exp, string tag);
    claim_req = 1; claim_ctx = c[0]; #1;
    chk(int'(claim_id), exp, tag);
    step(tag);
  endtask

  task automatic complete(int id);
    cmpl_req = 1; cmpl_id = 5'(id); step("R6 complete");
  endtask

  initial begin
    #(20 * 20000);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSRC; s++) begin mprio[s] = 0; mpend[s] = 0; mclm[s] = 0; end
    for (int c = 0; c < NCTX; c++) begin mthr[c] = 0; for (int s = 0; s < NSRC; s++) men[c][s] = 0; end
    repeat (2) @(negedge clk);
    rst_n = 1;
    src_level = 16'hFFFF;
    claim(0, 0, "R10 reset claim");
    src_level = '0;
    step("R10 idle");
    set_prio(3, 5); set_prio(5, 5); set_prio(7, 2); set_prio(9, 4);
    prio_we = 1; prio_idx = 0; prio_val = 3'd7; step("R3 id0 prio");
    en_we = 1; en_ctx = 0; en_mask = 16'h00A8; step("R1 en0");
    en_we = 1; en_ctx = 1; en_mask = 16'h0200; step("R1 en1");
    thr_we = 1; thr_ctx = 0; thr_val = 3'd1; step("R2 thr0");
    thr_we = 1; thr_ctx = 1; thr_val = 3'd4; step("R2 thr1");
    src_level = 16'h0280;
    #1 chk(int'(m_irq[0]), 0, "R8 not yet registered");
    step("R8 raise");
    chk(int'(m_irq[0]), 1, "R8 pending follows level");
    chk(int'(s_irq[1]), 0, "R2 equal threshold masked");
    thr_we = 1; thr_ctx = 1; thr_val = 3'd3; step("R2 thr1 lower");
    chk(int'(s_irq[1]), 1, "R7 supervisor line");
    chk(int'(m_irq[1]), 0, "R7 machine line idle");
    claim(0, 7, "R3 single winner");
    chk(int'(m_irq[0]), 0, "R9 line drops after claim");
    complete(7);
    chk(int'(m_irq[0]), 1, "R6 completion releases");
    src_level = 16'h02A8;
    step("R8 raise more");
    claim(0, 3, "R3 tie lowest id");
    claim(0, 5, "R3 second of tie");
    claim(0, 7, "R3 lower priority last");
    claim(0, 0, "R4 nothing left");
    chk(int'(m_irq[0]), 0, "R4 no line");
    complete(20);
    claim(0, 0, "R6 out of range ignored");
    complete(3);
    claim(0, 3, "R6 in range completes");
    thr_we = 1; thr_ctx = 0; thr_val = 3'd2; step("R2 thr0 raise");
    complete(7);
    claim(0, 0, "R2 priority equal to threshold");
    thr_we = 1; thr_ctx = 0; thr_val = 3'd1; en_we = 1; en_ctx = 0; en_mask = 16'h0020;
    step("R1 mask change");
    chk(int'(m_irq[0]), 0, "R1 disabled source ignored");
    claim(1, 9, "R7 supervisor claim");
    complete(9);
    src_level = '0;
    step("R8 drop"); step("R8 settle");
    chk(int'(s_irq[1]), 0, "R8 low level clears pending");
    for (int i = 0; i < 20; i++) begin
      src_level = 16'(i * 16'h1357);
      claim_req = i[0]; claim_ctx = i[1];
      cmpl_req = i[2]; cmpl_id = 5'(i % 17);
      step("R3 mixed");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    done = 1;
    $finish;
  end
endmodule